// File: doc/BRIEF.md
# Dual-Channel Status Block Buffer

This block holds the channel status of a two-subframe audio link. The block is 192 bits per subframe, and the A and B subframes are kept as separate copies. Three block-sized stages hold the data. The capture stage fills one bit per frame from the receive side. The middle stage is the only one a host can reach. The playout stage sends one bit per frame to the transmit side. At a receive block boundary the whole capture block moves into the middle stage. At a transmit block boundary the middle stage moves into the playout stage. Each of these two moves has its own inhibit, and the first five bytes of the middle stage can be shielded from receive updates.

The host reaches the middle stage one byte at a time through a byte pointer that steps forward by itself. In single-byte mode, a write updates the A and B copies of the addressed byte together, and a read returns the A or B copy as a configuration bit selects. In paired mode, every byte position takes two accesses, the A byte first and then the B byte. The pointer steps forward only after the B byte. Each completed move raises a one-cycle pulse for an interrupt controller.

Top module: `chstat_buf`

## Requirements
- R1: After reset, every bit of the middle and playout stages is 0, and `host_rdata`, `tx_a_bit`, `tx_b_bit`, `d2e_pulse` and `e2f_pulse` are 0.
- R2: Host byte k holds stream bits 8k to 8k+7 of its subframe. Stream bit 8k is in bit 7 and stream bit 8k+7 is in bit 0, so bit 7 of byte 0 is the first bit of the block, the consumer/professional flag. A read returns the middle-stage byte as it stood before the clock edge that performs the read, and `host_rdata` is updated only by a read.
- R3: A receive strobe with `rx_blk_start` high stores its bits at stream index 0. Each later strobe uses the next index, and the index wraps to 0 after 191. On the strobe that stores index 191, the full capture block, including that bit, is copied into the middle stage, and `d2e_pulse` is high for the following cycle.
- R4: With `cfg_inh_d2e` high at the boundary strobe, the middle stage is left unchanged and no pulse is raised. The move is dropped, not deferred, so the next move happens at the next boundary with the inhibit low.
- R5: With `cfg_protect` high, a receive move leaves bytes 0 to 4 of both copies unchanged and updates bytes 5 to 23.
- R6: In single-byte mode (`cfg_two_byte` = 0), a host write stores `host_wdata` into the A and B copies of the addressed byte.
- R7: In single-byte mode, a host read returns the A copy when `cfg_rd_sel_b` = 0 and the B copy when it is 1.
- R8: In paired mode (`cfg_two_byte` = 1), the first access at a position reaches the A copy and the second reaches the B copy, for reads and writes alike. The pointer advances only after the B access.
- R9: The pointer wraps from byte 23 to byte 0. A load sets the pointer to `host_ptr_val` (0 if that value is above 23) and restarts at the A access. A read or write in the same cycle as a load is ignored. When write and read come together, only the write happens.
- R10: A transmit request with `tx_blk_start` high and `cfg_inh_e2f` low loads the playout stage from the middle stage as it stood before that edge. `e2f_pulse` is high for the following cycle. Each request sends the playout bits at its index (0 on a start request, then rising, wrapping after 191) on `tx_a_bit`/`tx_b_bit`, valid from the cycle after the request and held until the next request. A start request sends bit 0 of the newly loaded block.
- R11: With `cfg_inh_e2f` high on a start request, the playout stage keeps its old block and no pulse is raised.
- R12: When a host write and a receive move fall in the same cycle, the addressed byte takes the host value and every other byte takes the moved data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit_vld | input | 1 | One received frame's status bits present |
| rx_blk_start | input | 1 | This frame is the first of a block |
| rx_a_bit | input | 1 | Status bit of subframe A |
| rx_b_bit | input | 1 | Status bit of subframe B |
| tx_bit_req | input | 1 | Transmitter asks for one frame's status bits |
| tx_blk_start | input | 1 | Requested frame starts a block |
| tx_a_bit | output | 1 | Sent status bit, subframe A |
| tx_b_bit | output | 1 | Sent status bit, subframe B |
| host_ptr_ld | input | 1 | Load the byte pointer |
| host_ptr_val | input | 5 | Byte position to load |
| host_wr | input | 1 | Host byte write |
| host_rd | input | 1 | Host byte read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered |
| cfg_two_byte | input | 1 | 1 = paired A/B access, 0 = single byte |
| cfg_rd_sel_b | input | 1 | Single-byte read source, 1 = B copy |
| cfg_protect | input | 1 | Shield bytes 0 to 4 from receive moves |
| cfg_inh_d2e | input | 1 | Block capture-to-middle moves |
| cfg_inh_e2f | input | 1 | Block middle-to-playout moves |
| d2e_pulse | output | 1 | Capture-to-middle move completed |
| e2f_pulse | output | 1 | Middle-to-playout move completed |

## Verification
A host write can land in the same cycle as the receive boundary strobe that overwrites the whole middle stage. The bench provokes this by sending 191 bits of a block and then asserting the final strobe and a single-byte write together. It then reads back the written byte, which must hold the host value in both copies, and the next byte, which must hold the received pattern. A transmit start request that samples the middle stage in the same cycle is also covered by the reference model, which compares every cycle.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
  localparam int unsigned BLK_BITS_DEF  = 192;
  localparam int unsigned PROT_BYTES_DEF = 5;

  typedef enum logic { PH_A = 1'b0, PH_B = 1'b1 } host_phase_e;
endpackage

// File: rtl/chstat_rx_stage.sv
module chstat_rx_stage #(
  parameter  int unsigned BITS = chstat_pkg::BLK_BITS_DEF,
  localparam int unsigned IW   = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_vld,
  input  logic            blk_start,
  input  logic            a_bit,
  input  logic            b_bit,
  output logic [BITS-1:0] d_a_nxt,
  output logic [BITS-1:0] d_b_nxt,
  output logic            blk_done
);
  logic [IW-1:0]   idx_q, idx_cur, idx_nxt;
  logic [BITS-1:0] d_a_q, d_b_q;

  always_comb begin
    idx_cur  = blk_start ? '0 : idx_q;
    idx_nxt  = idx_q;
    d_a_nxt  = d_a_q;
    d_b_nxt  = d_b_q;
    blk_done = 1'b0;
    if (bit_vld) begin
      d_a_nxt[idx_cur] = a_bit;
      d_b_nxt[idx_cur] = b_bit;
      blk_done = (idx_cur == IW'(BITS - 1));
      idx_nxt  = blk_done ? '0 : idx_cur + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      d_a_q <= '0;
      d_b_q <= '0;
    end else if (bit_vld) begin
      idx_q <= idx_nxt;
      d_a_q <= d_a_nxt;
      d_b_q <= d_b_nxt;
    end
  end
endmodule

// File: rtl/chstat_host_port.sv
module chstat_host_port #(
  parameter  int unsigned BYTES = chstat_pkg::BLK_BITS_DEF / 8,
  localparam int unsigned AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_ld,
  input  logic [AW-1:0] ptr_val,
  input  logic          wr,
  input  logic          rd,
  input  logic          two_byte,
  input  logic          rd_sel_b,
  output logic [AW-1:0] ptr,
  output logic          wr_a,
  output logic          wr_b,
  output logic          rd_go,
  output logic          rd_b
);
  import chstat_pkg::*;

  host_phase_e   phase_q, phase_nxt;
  logic [AW-1:0] ptr_q, ptr_nxt;
  logic          wr_go, acc, in_b, step;

  always_comb begin
    wr_go = wr & ~ptr_ld;
    rd_go = rd & ~wr & ~ptr_ld;
    acc   = wr_go | rd_go;
    in_b  = two_byte & (phase_q == PH_B);
    wr_a  = wr_go & (~two_byte | ~in_b);
    wr_b  = wr_go & (~two_byte | in_b);
    rd_b  = two_byte ? in_b : rd_sel_b;
    step  = acc & (~two_byte | in_b);

    ptr_nxt = ptr_q;
    if (ptr_ld)
      ptr_nxt = (ptr_val > AW'(BYTES - 1)) ? '0 : ptr_val;
    else if (step)
      ptr_nxt = (ptr_q == AW'(BYTES - 1)) ? '0 : ptr_q + 1'b1;

    phase_nxt = phase_q;
    if (ptr_ld || !two_byte) phase_nxt = PH_A;
    else if (acc)            phase_nxt = in_b ? PH_A : PH_B;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      phase_q <= PH_A;
    end else begin
      ptr_q   <= ptr_nxt;
      phase_q <= phase_nxt;
    end
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/chstat_tx_stage.sv
module chstat_tx_stage #(
  parameter  int unsigned BITS = chstat_pkg::BLK_BITS_DEF,
  localparam int unsigned IW   = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_req,
  input  logic            blk_start,
  input  logic            inh,
  input  logic [BITS-1:0] e_a,
  input  logic [BITS-1:0] e_b,
  output logic            a_bit,
  output logic            b_bit,
  output logic            loaded
);
  logic [IW-1:0]   idx_q, idx_cur, idx_nxt;
  logic [BITS-1:0] f_a_q, f_b_q, src_a, src_b;
  logic            load;

  always_comb begin
    idx_cur = blk_start ? '0 : idx_q;
    idx_nxt = (idx_cur == IW'(BITS - 1)) ? '0 : idx_cur + 1'b1;
    load    = bit_req & blk_start & ~inh;
    src_a   = load ? e_a : f_a_q;
    src_b   = load ? e_b : f_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      f_a_q  <= '0;
      f_b_q  <= '0;
      a_bit  <= 1'b0;
      b_bit  <= 1'b0;
      loaded <= 1'b0;
    end else begin
      loaded <= load;
      if (bit_req) begin
        idx_q <= idx_nxt;
        a_bit <= src_a[idx_cur];
        b_bit <= src_b[idx_cur];
      end
      if (load) begin
        f_a_q <= e_a;
        f_b_q <= e_b;
      end
    end
  end
endmodule

// File: rtl/chstat_buf.sv
module chstat_buf #(
  parameter  int unsigned BLK_BITS   = chstat_pkg::BLK_BITS_DEF,
  parameter  int unsigned PROT_BYTES = chstat_pkg::PROT_BYTES_DEF,
  localparam int unsigned BYTES      = BLK_BITS / 8,
  localparam int unsigned AW         = $clog2(BYTES),
  localparam int unsigned BW         = $clog2(BLK_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_bit_vld,
  input  logic          rx_blk_start,
  input  logic          rx_a_bit,
  input  logic          rx_b_bit,
  input  logic          tx_bit_req,
  input  logic          tx_blk_start,
  output logic          tx_a_bit,
  output logic          tx_b_bit,
  input  logic          host_ptr_ld,
  input  logic [AW-1:0] host_ptr_val,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  input  logic          cfg_two_byte,
  input  logic          cfg_rd_sel_b,
  input  logic          cfg_protect,
  input  logic          cfg_inh_d2e,
  input  logic          cfg_inh_e2f,
  output logic          d2e_pulse,
  output logic          e2f_pulse
);
  localparam logic [BLK_BITS-1:0] PROT_MASK =
    {{(BLK_BITS - PROT_BYTES * 8){1'b0}}, {(PROT_BYTES * 8){1'b1}}};

  logic [1:0]          rst_pipe;
  logic                rst_int_n;
  logic [BLK_BITS-1:0] d_a_nxt, d_b_nxt, e_a_q, e_b_q, e_a_nxt, e_b_nxt, keep;
  logic                blk_done, d2e_go;
  logic [AW-1:0]       ptr;
  logic                wr_a, wr_b, rd_go, rd_b;
  logic [BW-1:0]       base;
  logic [7:0]          rd_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  chstat_rx_stage #(.BITS(BLK_BITS)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .bit_vld(rx_bit_vld), .blk_start(rx_blk_start),
    .a_bit(rx_a_bit), .b_bit(rx_b_bit), .d_a_nxt(d_a_nxt), .d_b_nxt(d_b_nxt),
    .blk_done(blk_done));

  chstat_host_port #(.BYTES(BYTES)) u_host (
    .clk(clk), .rst_n(rst_int_n), .ptr_ld(host_ptr_ld), .ptr_val(host_ptr_val),
    .wr(host_wr), .rd(host_rd), .two_byte(cfg_two_byte), .rd_sel_b(cfg_rd_sel_b),
    .ptr(ptr), .wr_a(wr_a), .wr_b(wr_b), .rd_go(rd_go), .rd_b(rd_b));

  chstat_tx_stage #(.BITS(BLK_BITS)) u_tx (
    .clk(clk), .rst_n(rst_int_n), .bit_req(tx_bit_req), .blk_start(tx_blk_start),
    .inh(cfg_inh_e2f), .e_a(e_a_q), .e_b(e_b_q), .a_bit(tx_a_bit), .b_bit(tx_b_bit),
    .loaded(e2f_pulse));

  always_comb begin
    base    = BW'({ptr, 3'b000});
    d2e_go  = blk_done & ~cfg_inh_d2e;
    keep    = cfg_protect ? PROT_MASK : '0;
    e_a_nxt = e_a_q;
    e_b_nxt = e_b_q;
    if (d2e_go) begin
      e_a_nxt = (d_a_nxt & ~keep) | (e_a_q & keep);
      e_b_nxt = (d_b_nxt & ~keep) | (e_b_q & keep);
    end
    // host byte overlays the move; stream bit 8k sits in byte bit 7
    for (int j = 0; j < 8; j++) begin
      if (wr_a) e_a_nxt[base + BW'(j)] = host_wdata[7 - j];
      if (wr_b) e_b_nxt[base + BW'(j)] = host_wdata[7 - j];
      rd_byte[7 - j] = rd_b ? e_b_q[base + BW'(j)] : e_a_q[base + BW'(j)];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      e_a_q      <= '0;
      e_b_q      <= '0;
      host_rdata <= '0;
      d2e_pulse  <= 1'b0;
    end else begin
      e_a_q     <= e_a_nxt;
      e_b_q     <= e_b_nxt;
      d2e_pulse <= d2e_go;
      if (rd_go) host_rdata <= rd_byte;
    end
  end
endmodule

// File: rtl/chstat_buf_chk.sv
module chstat_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_bit_vld,
  input logic       tx_bit_req,
  input logic       tx_blk_start,
  input logic       cfg_inh_d2e,
  input logic       cfg_inh_e2f,
  input logic       host_rd,
  input logic       host_wr,
  input logic       host_ptr_ld,
  input logic [7:0] host_rdata,
  input logic       tx_a_bit,
  input logic       tx_b_bit,
  input logic       d2e_pulse,
  input logic       e2f_pulse
);
  AST_D2E_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    d2e_pulse |-> $past(rx_bit_vld)); // R3
  AST_D2E_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    d2e_pulse |-> !$past(cfg_inh_d2e)); // R4
  AST_E2F_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    e2f_pulse |-> $past(tx_bit_req && tx_blk_start)); // R10
  AST_E2F_NOT_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    e2f_pulse |-> !$past(cfg_inh_e2f)); // R11
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit_req |=> ($stable(tx_a_bit) && $stable(tx_b_bit))); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_rd && !host_wr && !host_ptr_ld) |=> $stable(host_rdata)); // R9
endmodule

bind chstat_buf chstat_buf_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rx_bit_vld(rx_bit_vld), .tx_bit_req(tx_bit_req),
  .tx_blk_start(tx_blk_start), .cfg_inh_d2e(cfg_inh_d2e), .cfg_inh_e2f(cfg_inh_e2f),
  .host_rd(host_rd), .host_wr(host_wr), .host_ptr_ld(host_ptr_ld),
  .host_rdata(host_rdata), .tx_a_bit(tx_a_bit), .tx_b_bit(tx_b_bit),
  .d2e_pulse(d2e_pulse), .e2f_pulse(e2f_pulse));

// File: tb/test_chstat_buf.sv
module test_chstat_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_bit_vld = 0, rx_blk_start = 0, rx_a_bit = 0, rx_b_bit = 0;
  logic tx_bit_req = 0, tx_blk_start = 0;
  logic tx_a_bit, tx_b_bit;
  logic host_ptr_ld = 0, host_wr = 0, host_rd = 0;
  logic [4:0] host_ptr_val = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic cfg_two_byte = 0, cfg_rd_sel_b = 0, cfg_protect = 0, cfg_inh_d2e = 0, cfg_inh_e2f = 0;
  logic d2e_pulse, e2f_pulse;

  int total = 0, bad = 0, d2e_cnt = 0, e2f_cnt = 0;
  bit live = 0;

  always #10 clk = ~clk;

  chstat_buf i_chstat_buf (.*);

  // reference model
  bit md_a[192], md_b[192], me_a[192], me_b[192], mf_a[192], mf_b[192];
  bit oe_a[192], oe_b[192];
  int mrx, mtx, mptr;
  bit mph, x_ta, x_tb, x_d2e, x_e2f;
  logic [7:0] x_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (md_a[i]) begin md_a[i]=0; md_b[i]=0; me_a[i]=0; me_b[i]=0; mf_a[i]=0; mf_b[i]=0; end
      mrx = 0; mtx = 0; mptr = 0; mph = 0; x_ta = 0; x_tb = 0; x_d2e = 0; x_e2f = 0; x_rd = 0;
    end else begin
      bit ld, wr, rd, inb, selb;
      int c;
      oe_a = me_a; oe_b = me_b;
      ld = host_ptr_ld; wr = host_wr && !ld; rd = host_rd && !host_wr && !ld;
      inb = cfg_two_byte && mph;
      if (rd) begin
        selb = cfg_two_byte ? inb : cfg_rd_sel_b;
        for (int j = 0; j < 8; j++) x_rd[7-j] = selb ? oe_b[mptr*8+j] : oe_a[mptr*8+j];
      end
      x_d2e = 0;
      if (rx_bit_vld) begin
        c = rx_blk_start ? 0 : mrx;
        md_a[c] = rx_a_bit; md_b[c] = rx_b_bit;
        if (c == 191) begin
          if (!cfg_inh_d2e) begin
            for (int i = 0; i < 192; i++)
              if (!(cfg_protect && i < 40)) begin me_a[i] = md_a[i]; me_b[i] = md_b[i]; end
            x_d2e = 1;
          end
          mrx = 0;
        end else mrx = c + 1;
      end
      if (wr) for (int j = 0; j < 8; j++) begin
        if (!cfg_two_byte || !inb) me_a[mptr*8+j] = host_wdata[7-j];
        if (!cfg_two_byte || inb)  me_b[mptr*8+j] = host_wdata[7-j];
      end
      if (ld) begin mptr = (host_ptr_val > 23) ? 0 : int'(host_ptr_val); mph = 0; end
      else begin
        if (wr || rd) begin
          if (!cfg_two_byte || inb) mptr = (mptr + 1) % 24;
          mph = cfg_two_byte && !inb;
        end
        if (!cfg_two_byte) mph = 0;
      end
      x_e2f = 0;
      if (tx_bit_req) begin
        c = tx_blk_start ? 0 : mtx;
        if (tx_blk_start && !cfg_inh_e2f) begin mf_a = oe_a; mf_b = oe_b; x_e2f = 1; end
        x_ta = mf_a[c]; x_tb = mf_b[c];
        mtx = (c == 191) ? 0 : c + 1;
      end
    end
  end

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) begin
    chk("R10 tx_a", {7'd0, tx_a_bit}, {7'd0, x_ta});
    chk("R10 tx_b", {7'd0, tx_b_bit}, {7'd0, x_tb});
    chk("R2 rdata", host_rdata, x_rd);
    chk("R3 d2e_pulse", {7'd0, d2e_pulse}, {7'd0, x_d2e});
    chk("R10 e2f_pulse", {7'd0, e2f_pulse}, {7'd0, x_e2f});
    if (d2e_pulse) d2e_cnt++;
    if (e2f_pulse) e2f_cnt++;
  end

  function automatic bit pa(int i, int s); return ((i * 7 + s) % 3) == 0; endfunction
  function automatic bit pb(int i, int s); return ((i + s) % 5) == 1; endfunction
  function automatic logic [7:0] xbyte(bit chb, int k, int s);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[7-j] = chb ? pb(8*k+j, s) : pa(8*k+j, s);
    return v;
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic hload(int p);
    host_ptr_ld = 1; host_ptr_val = 5'(p); tick(); host_ptr_ld = 0;
  endtask
  task automatic hwr(logic [7:0] v);
    host_wr = 1; host_wdata = v; tick(); host_wr = 0;
  endtask
  task automatic hrd(output logic [7:0] v);
    host_rd = 1; tick(); host_rd = 0; v = host_rdata;
  endtask
  task automatic rxbit(int i, int s);
    rx_bit_vld = 1; rx_blk_start = (i == 0); rx_a_bit = pa(i, s); rx_b_bit = pb(i, s);
    tick(); rx_bit_vld = 0; rx_blk_start = 0;
  endtask
  task automatic rxblock(int s);
    for (int i = 0; i < 192; i++) rxbit(i, s);
  endtask
  task automatic txblock(int s, string tag);
    int miss = 0;
    for (int i = 0; i < 192; i++) begin
      tx_bit_req = 1; tx_blk_start = (i == 0); tick();
      tx_bit_req = 0; tx_blk_start = 0;
      if (tx_a_bit !== pa(i, s) || tx_b_bit !== pb(i, s)) miss++;
    end
    chk(tag, 8'(miss), 8'd0);
  endtask

  logic [7:0] v;
  int n0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    live = 1;
    // R1 reset state
    chk("R1 rdata", host_rdata, 8'h00);
    chk("R1 tx", {6'd0, tx_a_bit, tx_b_bit}, 8'h00);
    chk("R1 pulses", {6'd0, d2e_pulse, e2f_pulse}, 8'h00);
    hload(12); hrd(v); chk("R1 E empty", v, 8'h00);
    // R6 / R7 single-byte write mirrors, read selects
    hload(3); hwr(8'hA5);
    hload(3); hrd(v); chk("R7 read A", v, 8'hA5);
    cfg_rd_sel_b = 1; hload(3); hrd(v); chk("R6 mirror B", v, 8'hA5);
    cfg_rd_sel_b = 0;
    // R8 / R9 paired access, wrap 23 -> 0
    cfg_two_byte = 1;
    hload(23); hwr(8'h11); hwr(8'h22); hwr(8'h33); hwr(8'h44);
    hload(23); hrd(v); chk("R8 A first", v, 8'h11);
    hrd(v); chk("R8 B second", v, 8'h22);
    hrd(v); chk("R9 wrap A", v, 8'h33);
    hrd(v); chk("R9 wrap B", v, 8'h44);
    cfg_two_byte = 0; cfg_rd_sel_b = 1;
    hload(0); hrd(v); chk("R7 read B", v, 8'h44);
    cfg_rd_sel_b = 0;
    // R9 access during load ignored; load above 23 gives 0
    host_ptr_ld = 1; host_ptr_val = 5'd2; host_wr = 1; host_wdata = 8'hEE; tick();
    host_ptr_ld = 0; host_wr = 0;
    hload(2); hrd(v); chk("R9 load+wr ignored", v, 8'h00);
    hload(30); hrd(v); chk("R9 load clamp", v, 8'h33);
    // R2 / R3 full receive block
    n0 = d2e_cnt;
    rxblock(1); tick();
    chk("R3 one move", 8'(d2e_cnt - n0), 8'd1);
    hload(0); hrd(v); chk("R2 byte0 A", v, xbyte(0, 0, 1));
    chk("R2 flag bit", {7'd0, v[7]}, {7'd0, pa(0, 1)});
    cfg_two_byte = 1; hload(10); hrd(v); chk("R3 byte10 A", v, xbyte(0, 10, 1));
    hrd(v); chk("R3 byte10 B", v, xbyte(1, 10, 1));
    cfg_two_byte = 0;
    // R10 playout
    n0 = e2f_cnt;
    txblock(1, "R10 block bits");
    chk("R10 one load", 8'(e2f_cnt - n0), 8'd1);
    // R5 protect
    cfg_protect = 1; rxblock(2); cfg_protect = 0;
    hload(4); hrd(v); chk("R5 byte4 kept", v, xbyte(0, 4, 1));
    hrd(v); chk("R5 byte5 moved", v, xbyte(0, 5, 2));
    // R4 inhibit drops move
    n0 = d2e_cnt;
    cfg_inh_d2e = 1; rxblock(3); cfg_inh_d2e = 0; tick();
    chk("R4 no pulse", 8'(d2e_cnt - n0), 8'd0);
    hload(5); hrd(v); chk("R4 E unchanged", v, xbyte(0, 5, 2));
    rxblock(3);
    hload(5); hrd(v); chk("R4 next boundary", v, xbyte(0, 5, 3));
    // R11 inhibit keeps playout block
    n0 = e2f_cnt;
    cfg_inh_e2f = 1; txblock(1, "R11 old block"); cfg_inh_e2f = 0;
    chk("R11 no pulse", 8'(e2f_cnt - n0), 8'd0);
    // R12 host write on the move cycle
    hload(7);
    for (int i = 0; i < 191; i++) rxbit(i, 4);
    rx_bit_vld = 1; rx_a_bit = pa(191, 4); rx_b_bit = pb(191, 4);
    host_wr = 1; host_wdata = 8'hC3; tick();
    rx_bit_vld = 0; host_wr = 0;
    cfg_two_byte = 1; hload(7);
    hrd(v); chk("R12 host wins A", v, 8'hC3);
    hrd(v); chk("R12 host wins B", v, 8'hC3);
    hrd(v); chk("R12 neighbour A", v, xbyte(0, 8, 4));
    hrd(v); chk("R12 neighbour B", v, xbyte(1, 8, 4));
    cfg_two_byte = 0;
    repeat (4) tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule